// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block performs one write at a time to an asynchronous static memory. A local requester presents an address, a two-bit bank select and a data word with a valid/ready handshake. Three programmable timing fields set how long each phase lasts: address setup, write-enable strobe and hold. When the block accepts a request, it samples the payload and all three fields. It then drives the memory pins through the phases in a fixed order.

Each field holds the length of its phase in clock cycles minus one, so a field value of zero still gives a one-cycle phase. Chip select, address, bank lines and write data stay stable from the first setup cycle to the last hold cycle. Write enable is low only during the strobe phase. The hold phase lets the memory's address-hold and data-hold windows close after write enable rises. The block reports `busy` for the whole access and pulses `done` in the final hold cycle. A new request can then be accepted one cycle later, so there is at least one idle cycle with chip select high between accesses.

Top module: `asram_wr_seq`

## Requirements
- R1: The phases always run in the order setup, strobe, hold. The setup phase lasts `cfg_setup`+1 cycles, so write enable first goes low in the cycle numbered `cfg_setup`+1, counting the first setup cycle as cycle 0.
- R2: `req_ready` is high only while no access is in progress. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the last hold cycle has ended.
- R3: `mem_cs_n` is low and `mem_dq_oe` is high for exactly `cfg_setup`+`cfg_strobe`+`cfg_hold`+3 consecutive cycles per access, starting in the cycle after acceptance.
- R4: `mem_we_n` is low for exactly `cfg_strobe`+1 consecutive cycles per access and is high during setup, during hold and while idle.
- R5: `mem_addr`, `mem_bank` and `mem_dq_out` equal the accepted request's values and do not change while `mem_cs_n` is low.
- R6: `done` is high for exactly one cycle per access, in the last cycle with `mem_cs_n` low. `busy` is high in every cycle of the access and low when idle.
- R7: The three timing fields are sampled at acceptance. Changing `cfg_setup`, `cfg_strobe` or `cfg_hold` during an access does not change that access's phase lengths.
- R8: If `req_valid` stays high, the next access is accepted in the idle cycle right after `done`. Between the two accesses, `mem_cs_n` is high for exactly one cycle.
- R9: While `rst_n` is low, and right after it is released, `mem_cs_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_ready`=1, `busy`=0 and `done`=0. This also applies when reset is asserted in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Word address for the write |
| req_bank | input | BANK_W | Bank select for the write |
| req_data | input | DATA_W | Write data |
| cfg_setup | input | SETUP_W | Setup phase length minus one |
| cfg_strobe | input | STROBE_W | Strobe phase length minus one |
| cfg_hold | input | HOLD_W | Hold phase length minus one |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse in the final hold cycle |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_bank | output | BANK_W | Memory bank lines |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | DATA_W | Memory data bus, output side |
| mem_dq_oe | output | 1 | Data bus output enable, active high |

## Verification
The bench uses the default parameters: 16-bit address and data, a 2-bit bank select, and timing fields of 4, 6 and 3 bits. With these widths, the all-zero case (a three-cycle access) and the all-ones case (15, 63 and 7, an 88-cycle access) both fit in a short run. These two extremes check that every counter load and every phase transition is right at the bottom and the top of each field. They also cover a change to the timing fields in the middle of an access, back-to-back requests with valid held high, and a reset arriving during the strobe phase.

// File: rtl/asram_wr_pkg.sv
package asram_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_phase_ctr.sv
module asram_phase_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = load_val;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_wr_fsm.sv
module asram_wr_fsm
  import asram_wr_pkg::*;
#(
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_fire,
  input  logic [SETUP_W-1:0]  cfg_setup,
  input  logic [STROBE_W-1:0] cfg_strobe,
  input  logic [HOLD_W-1:0]   cfg_hold,
  input  logic                cnt_zero,
  output phase_e              phase_q,
  output phase_e              phase_d,
  output logic                ctr_load,
  output logic [CNT_W-1:0]    ctr_val
);

  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;

  // Strobe and hold lengths are frozen at acceptance; setup goes straight to the counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= '0;
      hold_q   <= '0;
    end else if (req_fire) begin
      strobe_q <= cfg_strobe;
      hold_q   <= cfg_hold;
    end
  end

  always_comb begin
    phase_d  = phase_q;
    ctr_load = 1'b0;
    ctr_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_fire) begin
          phase_d  = PH_SETUP;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(cfg_setup);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d  = PH_STROBE;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(strobe_q);
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d  = PH_HOLD;
          ctr_load = 1'b1;
          ctr_val  = CNT_W'(hold_q);
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  // R1: phases only ever advance by one step, wrapping from hold back to idle
  a_r1_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> (2'(phase_q) == 2'(2'($past(phase_q)) + 2'd1)));

endmodule

// File: rtl/asram_pin_drv.sv
module asram_pin_drv
  import asram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [DATA_W-1:0] in_data,
  input  phase_e            phase_d,
  output logic              cs_n,
  output logic              we_n,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [DATA_W-1:0] dq
);

  logic active_d;
  logic strobe_d;

  always_comb begin
    active_d = (phase_d != PH_IDLE);
    strobe_d = (phase_d == PH_STROBE);
  end

  // Control pins come straight from flops, so they cannot glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      cs_n  <= !active_d;
      we_n  <= !strobe_d;
      dq_oe <= active_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      bank <= '0;
      dq   <= '0;
    end else if (capture) begin
      addr <= in_addr;
      bank <= in_bank;
      dq   <= in_data;
    end
  end

  // R4: write enable low only while chip select and data drive are on
  a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && dq_oe));

endmodule

// File: rtl/asram_wr_seq.sv
module asram_wr_seq
  import asram_wr_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [SETUP_W-1:0]  cfg_setup,
  input  logic [STROBE_W-1:0] cfg_strobe,
  input  logic [HOLD_W-1:0]   cfg_hold,
  output logic                busy,
  output logic                done,
  output logic                mem_cs_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BANK_W-1:0]   mem_bank,
  output logic                mem_we_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe
);

  localparam int CNT_W = max3(SETUP_W, STROBE_W, HOLD_W);

  phase_e           phase_q;
  phase_e           phase_d;
  logic             ctr_load;
  logic [CNT_W-1:0] ctr_val;
  logic             cnt_zero;
  logic             req_fire;

  always_comb begin
    req_ready = (phase_q == PH_IDLE);
    req_fire  = req_valid && req_ready;
    busy      = !req_ready;
    done      = (phase_q == PH_HOLD) && cnt_zero;
  end

  asram_wr_fsm #(
    .SETUP_W  (SETUP_W),
    .STROBE_W (STROBE_W),
    .HOLD_W   (HOLD_W),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .cnt_zero   (cnt_zero),
    .phase_q    (phase_q),
    .phase_d    (phase_d),
    .ctr_load   (ctr_load),
    .ctr_val    (ctr_val)
  );

  asram_phase_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .zero     (cnt_zero)
  );

  asram_pin_drv #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (req_fire),
    .in_addr (req_addr),
    .in_bank (req_bank),
    .in_data (req_data),
    .phase_d (phase_d),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .dq_oe   (mem_dq_oe),
    .addr    (mem_addr),
    .bank    (mem_bank),
    .dq      (mem_dq_out)
  );

  // R2: an idle, ready block never has the memory selected
  a_r2_ready_means_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  // R3: data drive follows chip select
  a_r3_oe_tracks_cs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe == !mem_cs_n);

  // R5: the payload stays frozen inside an access
  a_r5_payload_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$past(mem_cs_n)) |->
      ($stable(mem_addr) && $stable(mem_bank) && $stable(mem_dq_out)));

  // R6: done marks the final selected cycle
  a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_cs_n ##1 (mem_cs_n && req_ready && !done)));

endmodule

// File: tb/asram_wr_seq_tb.sv
module asram_wr_seq_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [1:0]  req_bank;
  logic [15:0] req_data;
  logic [3:0]  cfg_setup;
  logic [5:0]  cfg_strobe;
  logic [2:0]  cfg_hold;
  logic        busy;
  logic        done;
  logic        mem_cs_n;
  logic [15:0] mem_addr;
  logic [1:0]  mem_bank;
  logic        mem_we_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;

  int total;
  int bad;
  bit finished;

  asram_wr_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_bank   (req_bank),
    .req_data   (req_data),
    .cfg_setup  (cfg_setup),
    .cfg_strobe (cfg_strobe),
    .cfg_hold   (cfg_hold),
    .busy       (busy),
    .done       (done),
    .mem_cs_n   (mem_cs_n),
    .mem_addr   (mem_addr),
    .mem_bank   (mem_bank),
    .mem_we_n   (mem_we_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "cs_n idle", int'(mem_cs_n), 1);
    check(req, "we_n idle", int'(mem_we_n), 1);
    check(req, "oe idle", int'(mem_dq_oe), 0);
    check(req, "ready idle", int'(req_ready), 1);
    check(req, "busy idle", int'(busy), 0);
    check(req, "done idle", int'(done), 0);
  endtask

  // One access; if chg is set, the timing fields are changed right after acceptance.
  task automatic run_write(input string req, input logic [15:0] a, input logic [1:0] b,
                           input logic [15:0] d, input int s, input int t, input int h,
                           input bit chg);
    int cs_low;
    int we_low;
    int first_we;
    int done_cnt;
    int done_at;
    int pay_bad;
    int rdy_hi;
    int busy_lo;
    cs_low = 0; we_low = 0; first_we = -1; done_cnt = 0; done_at = -1;
    pay_bad = 0; rdy_hi = 0; busy_lo = 0;
    @(negedge clk);
    req_addr   = a;
    req_bank   = b;
    req_data   = d;
    cfg_setup  = 4'(s);
    cfg_strobe = 6'(t);
    cfg_hold   = 3'(h);
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_data  = ~d;
    if (chg) begin
      cfg_setup  = 4'(s + 7);
      cfg_strobe = 6'(t + 9);
      cfg_hold   = 3'(h + 5);
    end
    for (int i = 0; i < 200; i++) begin
      if (mem_cs_n) break;
      cs_low++;
      if (mem_addr != a || mem_bank != b || mem_dq_out != d || !mem_dq_oe) pay_bad++;
      if (!mem_we_n) begin
        we_low++;
        if (first_we < 0) first_we = i;
      end
      if (done) begin
        done_cnt++;
        done_at = i;
      end
      if (req_ready) rdy_hi++;
      if (!busy) busy_lo++;
      @(negedge clk);
    end
    check(req, "cs low cycles (R3)", cs_low, s + t + h + 3);
    check(req, "we low cycles (R4)", we_low, t + 1);
    check(req, "first we cycle (R1)", first_we, s + 1);
    check(req, "payload/oe mismatches (R5)", pay_bad, 0);
    check(req, "done count (R6)", done_cnt, 1);
    check(req, "done position (R6)", done_at, cs_low - 1);
    check(req, "ready high in access (R2)", rdy_hi, 0);
    check(req, "busy low in access (R6)", busy_lo, 0);
    check_idle(req);
  endtask

  task automatic test_reset_state();
    check_idle("R9");
  endtask

  task automatic test_back_to_back();
    int acc;
    int runs;
    int gap;
    bit drop;
    logic prev;
    acc = 0; runs = 0; gap = 0; drop = 1'b0; prev = 1'b1;
    @(negedge clk);
    req_addr   = 16'h00C3;
    req_bank   = 2'd1;
    req_data   = 16'h5A5A;
    cfg_setup  = 4'd1;
    cfg_strobe = 6'd1;
    cfg_hold   = 3'd0;
    req_valid  = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (req_valid && req_ready) begin
        acc++;
        if (acc == 2) drop = 1'b1;
      end
      @(negedge clk);
      if (drop) begin
        req_valid = 1'b0;
        drop = 1'b0;
      end
      if (!mem_cs_n && prev) runs++;
      if (mem_cs_n && runs == 1) gap++;
      prev = mem_cs_n;
    end
    check("R8", "accesses accepted", acc, 2);
    check("R8", "select runs", runs, 2);
    check("R8", "deselect gap", gap, 1);
  endtask

  task automatic test_reset_mid_access();
    @(negedge clk);
    req_addr   = 16'h1234;
    req_bank   = 2'd2;
    req_data   = 16'h0F0F;
    cfg_setup  = 4'd2;
    cfg_strobe = 6'd10;
    cfg_hold   = 3'd3;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R9", "we low before reset", int'(mem_we_n), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R9");
  endtask

  initial begin
    total = 0;
    bad = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_bank = '0;
    req_data = '0;
    cfg_setup = '0;
    cfg_strobe = '0;
    cfg_hold = '0;
    repeat (3) @(negedge clk);
    test_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset_state();
    run_write("R3", 16'hBEEF, 2'd3, 16'hCAFE, 0, 0, 0, 1'b0);
    run_write("R1", 16'h0101, 2'd0, 16'hA5A5, 2, 3, 1, 1'b0);
    run_write("R4", 16'hFFFF, 2'd2, 16'h8001, 15, 63, 7, 1'b0);
    run_write("R7", 16'h4321, 2'd1, 16'h1357, 1, 2, 1, 1'b1);
    test_back_to_back();
    test_reset_mid_access();
    run_write("R5", 16'h7E81, 2'd1, 16'h3C3C, 4, 0, 2, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule